// File: doc/BRIEF.md
# I2C Slave Read-Transfer Engine

This block is the slave side of an I2C bus for transfers in which the master reads. It samples SCL and SDA on the system clock and detects start and stop conditions. It collects the address byte and compares it with three programmable 7-bit addresses and with the general-call address. When an addressed master asks for data, the block shifts bytes out of a one-byte transmit register.

Software works through strobes and status bits. These are: the transmit register being empty, a byte having finished with nothing queued behind it, a NACK from the master, a stop condition having been seen, transmit mode, and which address matched.

Between bytes the engine stretches the clock. When a byte ends with nothing queued, or with a NACK, the engine holds SCL low from the ninth falling edge. SCL stays low until software performs a dummy read of the receive register. Both bus lines are open-drain: each output only pulls its line low.

Top module: `i2c_slave_tx_ctrl`

## Requirements
- R1: A falling SDA while SCL is high is a start and begins collection of an address byte. A rising SDA while SCL is high is a stop and sets `st_stop`.
- R2: The address is received MSB first, seven bits, then the R/W bit. A match against any of the three slots sets the matching bit of `st_slot_hit` (bit i for slot i) on the ninth SCL rising edge. Address 0 sets `st_gcall`. Without a match the block leaves SDA released in the ninth clock and sets no match indication.
- R3: For a matched address, SDA is pulled low during the ninth clock when `ack_bit_val` is 0 and is left released when it is 1.
- R4: A matched address with R/W = 1 sets both `st_tx_mode` and `st_tx_empty`. With R/W = 0, `st_tx_mode` stays 0.
- R5: A `txd_wr` pulse stores `txd_in`, clears `st_tx_empty` and clears `st_tx_end`. `st_tx_empty` returns to 1 as soon as the byte moves into the shifter, so a second byte can be queued while the first one is shifting.
- R6: Data bits are sent MSB first and SDA changes only while SCL is low. SDA is released during the master's acknowledge slot.
- R7: After a read address has been acknowledged with the transmit register empty, SCL is held low until a byte is written.
- R8: When a byte and its acknowledge slot finish with the transmit register empty, `st_tx_end` is set and SCL is held low from the ninth falling edge. A `rxd_rd` pulse releases SCL, after the next byte is loaded if one is queued.
- R9: With `nack_hold_en` = 1, a NACK from the master sets `st_nack` and holds SCL low. After `rxd_rd` no further byte is sent and SDA stays released. With `nack_hold_en` = 0, a NACK leaves `st_nack` at 0 and a queued byte is still sent.
- R10: A stop condition clears `st_slot_hit`, `st_gcall`, `st_tx_empty`, `st_tx_end` and `st_tx_mode`, and releases both lines.
- R11: `st_stop` and `st_nack` stay set until `stop_clr` or `nack_clr` respectively is pulsed.
- R12: After reset both lines are released and every status output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| scl_pull_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_low | output | 1 | 1 pulls SDA low |
| slot_addr | input | 21 | Three 7-bit slave addresses, slot i at bits 7i+6..7i |
| ack_bit_val | input | 1 | Value answered in the address acknowledge slot (0 = ACK) |
| nack_hold_en | input | 1 | Suspend transmission on a master NACK |
| txd_wr | input | 1 | Write strobe for the transmit register |
| txd_in | input | 8 | Byte to transmit |
| rxd_rd | input | 1 | Receive-register read strobe (releases a stretch) |
| nack_clr | input | 1 | Clears the NACK flag |
| stop_clr | input | 1 | Clears the stop flag |
| st_tx_empty | output | 1 | Transmit register empty |
| st_tx_end | output | 1 | Byte finished with no successor |
| st_nack | output | 1 | Master answered NACK |
| st_stop | output | 1 | Stop condition seen |
| st_tx_mode | output | 1 | Slave transmit mode active |
| st_slot_hit | output | 3 | Which address slot matched |
| st_gcall | output | 1 | General-call address matched |

## Verification
The hardest situation to reach is a clock stretch that a master actually waits on. The master releases SCL, but the line must stay low until software has written and then dummy-read. The bench models both lines as wired-AND and acts as the master, waiting on the resolved SCL level before each high phase. In the same sequence it acts as software, so it can check that SCL stays low, then issue the write and the read and watch the next byte leave. Random transfers vary the address (hits on each slot and misses), the byte count and the data. Directed cases cover the address NACK, the general call, the queued-byte path that never stretches, and a NACK with suspend disabled.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  typedef enum logic [2:0] {
    ST_IGNORE,
    ST_ADDR,
    ST_AACK,
    ST_WAITD,
    ST_LOAD,
    ST_TXB,
    ST_TACK,
    ST_HOLD
  } stx_state_e;
endpackage

// File: rtl/i2c_stx_linemon.sv
module i2c_stx_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & ~sda_lvl & sda_d;
  assign stop_det  = scl_lvl & scl_d & sda_lvl & ~sda_d;
endmodule

// File: rtl/i2c_stx_addr_match.sv
module i2c_stx_addr_match #(
  parameter int NSLOT = 3,
  parameter int AW    = 7
) (
  input  logic [AW:0]          rx_byte,
  input  logic [NSLOT*AW-1:0]  slots,
  output logic [NSLOT-1:0]     slot_hit,
  output logic                 gcall_hit
);
  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    assign slot_hit[gi] = (rx_byte[AW:1] == slots[gi*AW +: AW]);
  end
  assign gcall_hit = (rx_byte[AW:1] == '0);
endmodule

// File: rtl/i2c_stx_engine.sv
module i2c_stx_engine
  import i2c_stx_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [NSLOT-1:0] slot_hit,
  input  logic             gcall_hit,
  output logic [DW-1:0]    rx_byte,
  input  logic             ack_bit_val,
  input  logic             nack_hold_en,
  input  logic             txd_wr,
  input  logic [DW-1:0]    txd_in,
  input  logic             rxd_rd,
  input  logic             nack_clr,
  input  logic             stop_clr,
  output logic             sda_low,
  output logic             scl_low,
  output logic             tx_empty,
  output logic             tx_end,
  output logic             nack_flag,
  output logic             stop_flag,
  output logic             tx_mode,
  output logic [NSLOT-1:0] hit_flags,
  output logic             gc_flag
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  stx_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr, sh, tdr;
  logic          mack_q;

  assign rx_byte = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IGNORE;
      cnt       <= '0;
      sr        <= '0;
      sh        <= '0;
      tdr       <= '0;
      mack_q    <= 1'b0;
      sda_low   <= 1'b0;
      scl_low   <= 1'b0;
      tx_empty  <= 1'b0;
      tx_end    <= 1'b0;
      nack_flag <= 1'b0;
      stop_flag <= 1'b0;
      tx_mode   <= 1'b0;
      hit_flags <= '0;
      gc_flag   <= 1'b0;
    end else begin
      if (nack_clr) nack_flag <= 1'b0;
      if (stop_clr) stop_flag <= 1'b0;
      if (txd_wr)   tdr       <= txd_in;
      case (state)
        ST_ADDR: begin
          if (scl_rise && cnt != CNT_FULL) begin
            sr  <= {sr[DW-2:0], sda_lvl};
            cnt <= cnt + CW'(1);
          end else if (scl_fall && cnt == CNT_FULL) begin
            if (|slot_hit || gcall_hit) begin
              state   <= ST_AACK;
              sda_low <= ~ack_bit_val;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_AACK: begin
          if (scl_rise) begin
            hit_flags <= slot_hit;
            gc_flag   <= gcall_hit;
            if (sr[0]) begin
              tx_mode  <= 1'b1;
              tx_empty <= 1'b1;
            end
          end else if (scl_fall) begin
            sda_low <= 1'b0;
            if (sr[0] && !ack_bit_val) begin
              state   <= ST_WAITD;
              scl_low <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_WAITD: if (!tx_empty) state <= ST_LOAD;
        ST_LOAD: begin
          sh       <= tdr;
          sda_low  <= ~tdr[DW-1];
          scl_low  <= 1'b0;
          tx_empty <= 1'b1;
          cnt      <= '0;
          state    <= ST_TXB;
        end
        ST_TXB: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              sda_low <= 1'b0;
              state   <= ST_TACK;
            end else begin
              sh      <= {sh[DW-2:0], 1'b0};
              sda_low <= ~sh[DW-2];
              cnt     <= cnt + CW'(1);
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            mack_q <= sda_lvl;
          end else if (scl_fall) begin
            if (mack_q && nack_hold_en) begin
              nack_flag <= 1'b1;
              scl_low   <= 1'b1;
              state     <= ST_HOLD;
            end else if (tx_empty) begin
              tx_end  <= 1'b1;
              scl_low <= 1'b1;
              state   <= ST_HOLD;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        ST_HOLD: begin
          if (rxd_rd) begin
            if (nack_flag || tx_empty) begin
              scl_low <= 1'b0;
              state   <= ST_IGNORE;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        default: ;
      endcase
      if (txd_wr) begin
        tx_empty <= 1'b0;
        tx_end   <= 1'b0;
      end
      if (start_det) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        sda_low <= 1'b0;
        scl_low <= 1'b0;
      end
      if (stop_det) begin
        state     <= ST_IGNORE;
        stop_flag <= 1'b1;
        tx_mode   <= 1'b0;
        tx_empty  <= 1'b0;
        tx_end    <= 1'b0;
        hit_flags <= '0;
        gc_flag   <= 1'b0;
        sda_low   <= 1'b0;
        scl_low   <= 1'b0;
      end
    end
  end

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!tx_mode && !tx_empty && !tx_end && hit_flags == '0 && !gc_flag
                  && stop_flag && !scl_low && !sda_low));

  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

  assert_read_releases_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && rxd_rd) |=> ##1 !scl_low);

  assert_nack_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (nack_flag && !nack_clr) |=> nack_flag);

  assert_write_clears_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (txd_wr && !stop_det) |=> (!tx_empty && !tx_end));
endmodule

// File: rtl/i2c_slave_tx_ctrl.sv
module i2c_slave_tx_ctrl #(
  parameter int NSLOT  = 3,
  parameter int AW     = 7,
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_pull_low,
  output logic                sda_pull_low,
  input  logic [NSLOT*AW-1:0] slot_addr,
  input  logic                ack_bit_val,
  input  logic                nack_hold_en,
  input  logic                txd_wr,
  input  logic [AW:0]         txd_in,
  input  logic                rxd_rd,
  input  logic                nack_clr,
  input  logic                stop_clr,
  output logic                st_tx_empty,
  output logic                st_tx_end,
  output logic                st_nack,
  output logic                st_stop,
  output logic                st_tx_mode,
  output logic [NSLOT-1:0]    st_slot_hit,
  output logic                st_gcall
);
  localparam int DW = AW + 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [NSLOT-1:0] slot_hit;
  logic gcall_hit;
  logic [DW-1:0] rx_byte;

  i2c_stx_linemon #(.STAGES(STAGES)) mon_i (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_stx_addr_match #(.NSLOT(NSLOT), .AW(AW)) match_i (
    .rx_byte(rx_byte), .slots(slot_addr), .slot_hit(slot_hit), .gcall_hit(gcall_hit)
  );

  i2c_stx_engine #(.NSLOT(NSLOT), .DW(DW)) eng_i (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .slot_hit(slot_hit), .gcall_hit(gcall_hit), .rx_byte(rx_byte),
    .ack_bit_val(ack_bit_val), .nack_hold_en(nack_hold_en),
    .txd_wr(txd_wr), .txd_in(txd_in), .rxd_rd(rxd_rd),
    .nack_clr(nack_clr), .stop_clr(stop_clr),
    .sda_low(sda_pull_low), .scl_low(scl_pull_low),
    .tx_empty(st_tx_empty), .tx_end(st_tx_end), .nack_flag(st_nack),
    .stop_flag(st_stop), .tx_mode(st_tx_mode), .hit_flags(st_slot_hit), .gc_flag(st_gcall)
  );
endmodule

// File: tb/i2c_slave_tx_ctrl_tb_top.sv
module i2c_slave_tx_ctrl_tb_top;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic scl_pull_low, sda_pull_low;
  logic [20:0] slot_addr;
  logic ack_bit_val = 1'b0, nack_hold_en = 1'b1;
  logic txd_wr = 1'b0, rxd_rd = 1'b0, nack_clr = 1'b0, stop_clr = 1'b0;
  logic [7:0] txd_in = 8'h00;
  logic st_tx_empty, st_tx_end, st_nack, st_stop, st_tx_mode, st_gcall;
  logic [2:0] st_slot_hit;
  logic [6:0] slotv [3];
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull_low;
  assign sda_line = sda_m & ~sda_pull_low;

  initial begin
    slotv[0] = 7'h2A; slotv[1] = 7'h51; slotv[2] = 7'h13;
  end
  assign slot_addr = {slotv[2], slotv[1], slotv[0]};

  i2c_slave_tx_ctrl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .slot_addr(slot_addr), .ack_bit_val(ack_bit_val), .nack_hold_en(nack_hold_en),
    .txd_wr(txd_wr), .txd_in(txd_in), .rxd_rd(rxd_rd),
    .nack_clr(nack_clr), .stop_clr(stop_clr),
    .st_tx_empty(st_tx_empty), .st_tx_end(st_tx_end), .st_nack(st_nack),
    .st_stop(st_stop), .st_tx_mode(st_tx_mode), .st_slot_hit(st_slot_hit), .st_gcall(st_gcall)
  );

  function automatic logic [2:0] exp_hit(input logic [6:0] a);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (a == slotv[i]);
    return r;
  endfunction

  task automatic hcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic smp);
    sda_m = b;
    hcyc(H);
    scl_m = 1'b1;
    hcyc(1);
    while (!scl_line) hcyc(1);
    hcyc(H / 2);
    smp = sda_line;
    hcyc(H / 2);
    scl_m = 1'b0;
    hcyc(2);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    hcyc(H);
    scl_m = 1'b1;
    while (!scl_line) hcyc(1);
    hcyc(H);
    sda_m = 1'b0;
    hcyc(H);
    scl_m = 1'b0;
    hcyc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    hcyc(H);
    scl_m = 1'b1;
    while (!scl_line) hcyc(1);
    hcyc(H);
    sda_m = 1'b1;
    hcyc(H);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ackd);
    logic [7:0] b;
    logic s;
    b = {a, rw};
    bus_start();
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ackd = ~s;
  endtask

  task automatic read_byte(input logic mnack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(mnack, s);
  endtask

  task automatic sw_write(input logic [7:0] d);
    txd_in = d; txd_wr = 1'b1; hcyc(1); txd_wr = 1'b0;
  endtask

  task automatic sw_read();
    rxd_rd = 1'b1; hcyc(1); rxd_rd = 1'b0;
  endtask

  task automatic sw_clear();
    nack_clr = 1'b1; stop_clr = 1'b1; hcyc(1); nack_clr = 1'b0; stop_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic ackd;
    logic [7:0] d, b1, b2, b3;
    int seed;
    seed = $urandom(32'd4711);
    hcyc(5);
    rst = 1'b0;
    hcyc(3);
    // R12 reset state
    chk("R12 scl", 32'(scl_pull_low), 0);
    chk("R12 sda", 32'(sda_pull_low), 0);
    chk("R12 status", 32'({st_tx_empty, st_tx_end, st_nack, st_stop, st_tx_mode, st_slot_hit, st_gcall}), 0);

    // Directed read from slot 1, three bytes, last NACKed with suspend enabled
    b1 = 8'hA5; b2 = 8'h3C; b3 = 8'h81;
    send_addr(slotv[1], 1'b1, ackd);
    chk("R3 address ack", 32'(ackd), 1);
    chk("R2 slot1 hit", 32'(st_slot_hit), 32'(3'b010));
    chk("R2 no gcall", 32'(st_gcall), 0);
    chk("R4 tx_mode", 32'(st_tx_mode), 1);
    chk("R4 tx_empty", 32'(st_tx_empty), 1);
    hcyc(30);
    chk("R7 stretch empty", 32'(scl_pull_low), 1);
    scl_m = 1'b1; hcyc(10);
    chk("R7 scl held", 32'(scl_line), 0);
    scl_m = 1'b0;
    sw_write(b1);
    hcyc(5);
    chk("R5 empty after move", 32'(st_tx_empty), 1);
    chk("R7 released", 32'(scl_pull_low), 0);
    sw_write(b2);
    chk("R5 write clears empty", 32'(st_tx_empty), 0);
    read_byte(1'b0, d);
    chk("R6 byte1", 32'(d), 32'(b1));
    read_byte(1'b0, d);
    chk("R6 byte2 queued", 32'(d), 32'(b2));
    hcyc(30);
    chk("R8 tx_end", 32'(st_tx_end), 1);
    chk("R8 stretch", 32'(scl_pull_low), 1);
    scl_m = 1'b1; hcyc(10);
    chk("R8 scl held", 32'(scl_line), 0);
    scl_m = 1'b0;
    sw_write(b3);
    chk("R5 write clears tx_end", 32'(st_tx_end), 0);
    hcyc(20);
    chk("R8 still held before read", 32'(scl_pull_low), 1);
    sw_read();
    hcyc(5);
    read_byte(1'b1, d);
    chk("R6 byte3", 32'(d), 32'(b3));
    hcyc(30);
    chk("R9 nack flag", 32'(st_nack), 1);
    chk("R9 stretch on nack", 32'(scl_pull_low), 1);
    sw_read();
    hcyc(5);
    chk("R8 released by read", 32'(scl_pull_low), 0);
    scl_m = 1'b1; hcyc(H); scl_m = 1'b0; hcyc(H);
    chk("R9 sda released", 32'(sda_pull_low), 0);
    bus_stop();
    hcyc(5);
    chk("R1 stop flag", 32'(st_stop), 1);
    chk("R10 cleared", 32'({st_tx_empty, st_tx_end, st_tx_mode, st_slot_hit, st_gcall}), 0);
    hcyc(50);
    chk("R11 nack sticky", 32'(st_nack), 1);
    chk("R11 stop sticky", 32'(st_stop), 1);
    sw_clear();
    chk("R11 cleared", 32'({st_nack, st_stop}), 0);

    // General call, write direction
    send_addr(7'h00, 1'b0, ackd);
    chk("R3 gcall ack", 32'(ackd), 1);
    chk("R2 gcall flag", 32'(st_gcall), 1);
    chk("R4 write keeps rx mode", 32'(st_tx_mode), 0);
    bus_stop(); hcyc(5);
    chk("R10 gcall cleared", 32'(st_gcall), 0);
    sw_clear();

    // Address answered with NACK by programmed value
    ack_bit_val = 1'b1;
    send_addr(slotv[0], 1'b1, ackd);
    chk("R3 programmed nack", 32'(ackd), 0);
    chk("R2 slot0 hit", 32'(st_slot_hit), 32'(3'b001));
    hcyc(30);
    chk("R3 no stretch", 32'(scl_pull_low), 0);
    bus_stop(); hcyc(5); sw_clear();
    ack_bit_val = 1'b0;

    // Non-matching address
    send_addr(7'h7E, 1'b1, ackd);
    chk("R2 miss no ack", 32'(ackd), 0);
    chk("R2 miss no hit", 32'({st_slot_hit, st_gcall}), 0);
    bus_stop(); hcyc(5); sw_clear();

    // NACK with suspend disabled
    nack_hold_en = 1'b0;
    b1 = 8'h6E; b2 = 8'hF0;
    send_addr(slotv[2], 1'b1, ackd);
    chk("R2 slot2 hit", 32'(st_slot_hit), 32'(3'b100));
    sw_write(b1); hcyc(5); sw_write(b2);
    read_byte(1'b1, d);
    chk("R6 byte1 nd", 32'(d), 32'(b1));
    read_byte(1'b1, d);
    chk("R9 queued byte sent after nack", 32'(d), 32'(b2));
    hcyc(30);
    chk("R9 no nack flag", 32'(st_nack), 0);
    chk("R8 tx_end nd", 32'(st_tx_end), 1);
    chk("R8 stretch nd", 32'(scl_pull_low), 1);
    sw_read(); hcyc(5);
    chk("R8 release nd", 32'(scl_pull_low), 0);
    bus_stop(); hcyc(5); sw_clear();
    nack_hold_en = 1'b1;

    // Random transfers
    for (int it = 0; it < 12; it++) begin
      logic [6:0] a;
      logic [2:0] eh;
      logic [7:0] dv;
      int nb;
      if ($urandom % 4 != 0) a = slotv[$urandom % 3];
      else a = 7'($urandom % 128);
      if (a == 7'h00) a = 7'h55;
      eh = exp_hit(a);
      send_addr(a, 1'b1, ackd);
      chk("R2 random hit", 32'(st_slot_hit), 32'(eh));
      chk("R3 random ack", 32'(ackd), 32'(eh != 3'b000));
      if (eh != 3'b000) begin
        nb = 1 + int'($urandom % 3);
        for (int k = 0; k < nb; k++) begin
          dv = 8'($urandom);
          sw_write(dv);
          if (k > 0) sw_read();
          hcyc(5);
          read_byte(k == nb - 1, d);
          chk("R6 random data", 32'(d), 32'(dv));
        end
        hcyc(30);
        chk("R9 random nack", 32'(st_nack), 1);
        sw_read(); hcyc(5);
      end
      bus_stop(); hcyc(5);
      chk("R10 random stop", 32'({st_stop, st_tx_mode, st_slot_hit}), 32'(8'h80 >> 3));
      sw_clear();
    end

    done = 1'b1;
    finish_run();
  end
endmodule